// File: doc/BRIEF.md
# Processor Privilege Mode Controller

This block keeps track of the operating mode of a 24-bit word processor built for time-sharing. It has three modes: normal, monitor and user. The processor starts in normal mode after reset. A special instruction moves it to monitor mode, and normal mode is never entered again until the next reset. Monitor mode hands control to a user program on a transfer strobe. User mode returns to monitor mode only on a system-operator call, a trap or an accepted interrupt.

Every issued instruction is checked against the current mode. A privileged instruction (for example halt or I/O) issued in user mode is suppressed: the execute stage receives a NOP-substitute signal in the same cycle. A trap request then follows at the next instruction boundary. Interrupts are latched and accepted at an instruction boundary. When a trap and an interrupt fall on the same boundary, the trap goes first. The code space for system-operator calls is split in half. Codes whose top bit is 1 are system calls, and codes whose top bit is 0 are user calls.

Top module: `priv_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 2'b00 (normal) and `nop_sub`, `trap_req`, `irq_ack` and `call_sys` are all 0. The mode encodings are 00 normal, 01 monitor and 10 user.
- R2: In normal mode, `enter_mon` moves `mode` to 01 on the next clock edge. System calls, traps and interrupts leave `mode` at 00.
- R3: Once `mode` has left 00 it never returns to 00. `enter_mon` has no effect in monitor or user mode.
- R4: In monitor mode, `to_user` moves `mode` to 10 on the next clock edge. `to_user` has no effect in normal or user mode.
- R5: In user mode, `mode` becomes 01 on the next clock edge after a cycle that has `call_valid`, `trap_req` or `irq_ack`. In every other case it stays at 10.
- R6: A cycle with `instr_valid` and `instr_priv` in user mode drives `nop_sub` high in that same cycle.
- R7: After such a suppressed instruction, `trap_req` is high during the next `instr_valid` cycle and then clears. `trap_in` drives `trap_req` directly in its own cycle.
- R8: Privileged instructions in normal or monitor mode produce no `nop_sub` and no later `trap_req`.
- R9: An `irq` pulse is held pending and acknowledged through `irq_ack` in the first `instr_valid` cycle that has no `trap_req`. If a trap falls on that boundary, the interrupt stays pending and is acknowledged at the following boundary.
- R10: `call_sys` equals `call_valid` AND the top bit of `call_code` (1 means a system call, 0 means a user call).
- R11: `mode` never holds the unused code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is issued (instruction boundary) |
| instr_priv | input | 1 | The issued instruction is privileged |
| enter_mon | input | 1 | Special instruction: normal to monitor |
| to_user | input | 1 | Transfer-to-user strobe |
| call_valid | input | 1 | System-operator call strobe |
| call_code | input | CALL_W | System-operator call code |
| trap_in | input | 1 | External trap request |
| irq | input | 1 | Interrupt request pulse |
| mode | output | 2 | Current mode |
| nop_sub | output | 1 | Replace the current instruction with a NOP |
| trap_req | output | 1 | Trap request to the sequencer |
| irq_ack | output | 1 | Interrupt accepted at this boundary |
| call_sys | output | 1 | The current call is a system-half call |

## Verification
`nop_sub`, `trap_req`, `irq_ack` and `call_sys` are combinational outputs. They are due in the same cycle as the stimulus that causes them. `mode` is registered, so it is due one clock edge after its stimulus.

The driver applies the inputs on the falling edge and queues one expected item per cycle. The monitor samples the combinational outputs 1 ns after that falling edge. It compares `mode` against the previous item's expected mode one full cycle later, after the rising edge has registered it. The deferred trap and the pending interrupt are checked at the first boundary cycle that follows, never at a fixed offset.

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl #(
  parameter int CALL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic              instr_priv,
  input  logic              enter_mon,
  input  logic              to_user,
  input  logic              call_valid,
  input  logic [CALL_W-1:0] call_code,
  input  logic              trap_in,
  input  logic              irq,
  output logic [1:0]        mode,
  output logic              nop_sub,
  output logic              trap_req,
  output logic              irq_ack,
  output logic              call_sys
);
  localparam logic [1:0] M_NORM = 2'b00;
  localparam logic [1:0] M_MON  = 2'b01;
  localparam logic [1:0] M_USER = 2'b10;

  logic [1:0] mode_q, mode_d;
  logic       priv_pend_q, irq_pend_q;
  logic       in_user;

  assign in_user  = (mode_q == M_USER);
  assign nop_sub  = instr_valid & instr_priv & in_user;
  assign trap_req = trap_in | (instr_valid & priv_pend_q);
  assign irq_ack  = instr_valid & (irq_pend_q | irq) & ~trap_req;
  assign call_sys = call_valid & call_code[CALL_W-1];
  assign mode     = mode_q;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      M_NORM:  if (enter_mon) mode_d = M_MON;
      M_MON:   if (to_user) mode_d = M_USER;
      M_USER:  if (call_valid | trap_req | irq_ack) mode_d = M_MON;
      default: mode_d = M_NORM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= M_NORM;
      priv_pend_q <= 1'b0;
      irq_pend_q  <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      priv_pend_q <= nop_sub | (priv_pend_q & ~instr_valid);
      irq_pend_q  <= (irq_pend_q | irq) & ~irq_ack;
    end
  end

  assert_mode_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'b11);
  assert_nop_only_user_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nop_sub |-> mode_q == M_USER);
  assert_no_return_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_NORM) |=> (mode_q != M_NORM));
  assert_trap_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> !irq_ack);
  assert_user_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_USER && !call_valid && !trap_in && !instr_valid) |=> mode_q == M_USER);
endmodule

// File: tb/priv_mode_ctrl_tb.sv
`timescale 1ns/100ps
module priv_mode_ctrl_tb;
  localparam int CALL_W = 4;
  localparam logic [6:0] IV = 7'b1000000, IP = 7'b0100000, EM = 7'b0010000,
                         TU = 7'b0001000, CV = 7'b0000100, TI = 7'b0000010,
                         IR = 7'b0000001, NONE = 7'b0;

  typedef struct {
    string      req;
    logic [3:0] comb;
    logic [1:0] mode_next;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic instr_valid = 0, instr_priv = 0, enter_mon = 0, to_user = 0;
  logic call_valid = 0, trap_in = 0, irq = 0;
  logic [CALL_W-1:0] call_code = '0;
  logic [1:0] mode;
  logic nop_sub, trap_req, irq_ack, call_sys;
  int checks = 0, fails = 0;
  item_t q[$];
  bit done = 0;

  always #2 clk = ~clk;

  priv_mode_ctrl #(.CALL_W(CALL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_priv(instr_priv),
    .enter_mon(enter_mon), .to_user(to_user), .call_valid(call_valid),
    .call_code(call_code), .trap_in(trap_in), .irq(irq), .mode(mode),
    .nop_sub(nop_sub), .trap_req(trap_req), .irq_ack(irq_ack), .call_sys(call_sys));

  task automatic cyc(string r, logic [6:0] s, logic [3:0] cc, logic [3:0] e_comb, logic [1:0] e_mode);
    item_t it;
    @(negedge clk);
    {instr_valid, instr_priv, enter_mon, to_user, call_valid, trap_in, irq} = s;
    call_code = cc;
    it.req = r; it.comb = e_comb; it.mode_next = e_mode;
    q.push_back(it);
  endtask

  task automatic check(string r, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", r, what, act, exp);
    end
  endtask

  initial begin : monitor
    item_t prev;
    bit have_prev = 0;
    forever begin
      @(negedge clk);
      #1;
      if (have_prev) check(prev.req, "mode", {2'b00, mode}, {2'b00, prev.mode_next});
      have_prev = 0;
      if (q.size() > 0) begin
        prev = q.pop_front();
        check(prev.req, "nop/trap/ack/sys", {nop_sub, trap_req, irq_ack, call_sys}, prev.comb);
        have_prev = 1;
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cyc("R1", NONE, 4'h0, 4'b0000, 2'b00);
    // normal mode: ignored events
    cyc("R4", TU, 4'h0, 4'b0000, 2'b00);
    cyc("R10", CV, 4'hA, 4'b0001, 2'b00);
    cyc("R2", TI, 4'h0, 4'b0100, 2'b00);
    cyc("R9", IR, 4'h0, 4'b0000, 2'b00);
    cyc("R9", IV, 4'h0, 4'b0010, 2'b00);
    cyc("R8", IV | IP, 4'h0, 4'b0000, 2'b00);
    cyc("R8", IV, 4'h0, 4'b0000, 2'b00);
    cyc("R2", EM, 4'h0, 4'b0000, 2'b01);
    // monitor mode
    cyc("R8", IV | IP, 4'h0, 4'b0000, 2'b01);
    cyc("R8", IV, 4'h0, 4'b0000, 2'b01);
    cyc("R3", EM, 4'h0, 4'b0000, 2'b01);
    cyc("R4", TU, 4'h0, 4'b0000, 2'b10);
    // user mode
    cyc("R4", TU, 4'h0, 4'b0000, 2'b10);
    cyc("R3", EM, 4'h0, 4'b0000, 2'b10);
    cyc("R5", IV, 4'h0, 4'b0000, 2'b10);
    cyc("R6", IV | IP, 4'h0, 4'b1000, 2'b10);
    cyc("R7", NONE, 4'h0, 4'b0000, 2'b10);
    cyc("R7", IV, 4'h0, 4'b0100, 2'b01);
    cyc("R4", TU, 4'h0, 4'b0000, 2'b10);
    cyc("R7", IV, 4'h0, 4'b0000, 2'b10);
    cyc("R10", CV, 4'h3, 4'b0000, 2'b01);
    cyc("R4", TU, 4'h0, 4'b0000, 2'b10);
    cyc("R5", IR, 4'h0, 4'b0000, 2'b10);
    cyc("R5", IV, 4'h0, 4'b0010, 2'b01);
    cyc("R4", TU, 4'h0, 4'b0000, 2'b10);
    cyc("R6", IV | IP, 4'h0, 4'b1000, 2'b10);
    cyc("R9", IR, 4'h0, 4'b0000, 2'b10);
    cyc("R9", IV, 4'h0, 4'b0100, 2'b01);
    cyc("R9", IV, 4'h0, 4'b0010, 2'b01);
    cyc("R3", NONE, 4'h0, 4'b0000, 2'b01);
    cyc("R1", NONE, 4'h0, 4'b0000, 2'b01);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule